// File: doc/BRIEF.md
# CAN Bus-Off Recovery Controller

This block decides when a CAN node that has dropped off the bus after a bus-off event may carry traffic again. It owns the software-visible initialisation bit. That bit comes out of reset set, and the hardware forces it set whenever the error logic reports bus-off. While the bit is set, the protocol engine is held off the bus.

After software clears the bit, a node that is not bus-off goes straight back on the bus. A node that is bus-off must first observe a long run of bus idle time. The block counts recessive bits, one per bit-time strobe. Every 11 consecutive recessive bits make one idle sequence. Once 129 idle sequences have been seen, the node rejoins the bus. At that point the block asserts bus-enable and gives a one-cycle done pulse, and the same pulse tells the error counters to clear.

A dominant bit restarts only the sequence in progress, so sequences already completed are kept. Software cannot shorten the wait: setting the bit again discards all progress, and a redundant clear has no effect. There is no data stream through the block, so every pin is plain level or pulse control with no handshake.

Top module: `can_busoff_recovery`

## Requirements
- R1: After reset, init_bit is 1, bus_en is 0, and recovery_done and err_clear are 0.
- R2: When not bus-off, writing 0 to the initialisation bit (init_wr_en=1, init_wr_data=0) sets bus_en to 1 on the next cycle. Writing 1 clears bus_en on the next cycle.
- R3: A busoff_evt pulse forces init_bit to 1 and bus_en to 0 on the next cycle, from any state. It takes priority over a write in the same cycle.
- R4: Clearing the initialisation bit while bus-off makes init_bit read 0, but bus_en stays 0 until the recovery completes.
- R5: The recovery completes on the strobe of the 129*11 = 1419th counted recessive bit (rx_bit=1). bus_en is still 0 after the 1418th such bit.
- R6: A dominant bit (rx_bit=0) sampled on a strobe during recovery discards the recessive bits of the unfinished sequence and keeps the completed sequences.
- R7: Bits are counted only in cycles where bit_strobe is 1. rx_bit held recessive without strobes makes no progress.
- R8: At completion, recovery_done and err_clear are both 1 for exactly one cycle, in the same cycle that bus_en first reads 1.
- R9: Writing 1 to the initialisation bit during recovery stops counting and discards progress, so a full 1419 recessive bits are needed after the next clear. Strobes while the bit is set are not counted, and a redundant write of 0 during recovery changes nothing.
- R10: A new busoff_evt during recovery restarts the recovery from zero and sets init_bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busoff_evt | input | 1 | One-cycle pulse: error logic entered bus-off |
| bit_strobe | input | 1 | One-cycle pulse per bit time; rx_bit is sampled when high |
| rx_bit | input | 1 | Sampled receive level, 1 = recessive, 0 = dominant |
| init_wr_en | input | 1 | Software write strobe for the initialisation bit |
| init_wr_data | input | 1 | Value written to the initialisation bit |
| init_bit | output | 1 | Readable initialisation bit |
| bus_en | output | 1 | Permits the protocol engine to take part in bus traffic |
| recovery_done | output | 1 | One-cycle pulse when the recovery sequence completes |
| err_clear | output | 1 | One-cycle request to clear the error counters |

## Verification
A corrupted recessive-bit or sequence count cannot be seen until the end of recovery. It shows up as bus_en rising one or more strobes too early or too late compared with the computed count of 1419 counted bits. For that reason the bench samples bus_en both one bit before and exactly at the expected completion. A wrong control state shows up at once on the next cycle: init_bit reads wrong, bus_en is high while bus-off, or the done pulse is missing or longer than one cycle.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    ST_CONFIG   = 2'd0,
    ST_ACTIVE   = 2'd1,
    ST_BO_HELD  = 2'd2,
    ST_BO_COUNT = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/cbr_run_counter.sv
module cbr_run_counter #(
  parameter int unsigned RUN_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic bit_strobe,
  input  logic rx_bit,
  output logic seq_tick
);
  localparam int unsigned CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] run_q;

  assign seq_tick = count_en && bit_strobe && rx_bit && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !count_en) begin
      run_q <= '0;
    end else if (bit_strobe) begin
      if (!rx_bit || run_q == LAST) run_q <= '0;
      else                          run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/cbr_seq_counter.sv
module cbr_seq_counter #(
  parameter int unsigned SEQ_NEEDED = 129
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic seq_tick,
  output logic seq_done
);
  localparam int unsigned SW = $clog2(SEQ_NEEDED + 1);
  localparam logic [SW-1:0] LAST = SW'(SEQ_NEEDED - 1);

  logic [SW-1:0] seq_q;

  assign seq_done = seq_tick && (seq_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !count_en) begin
      seq_q <= '0;
    end else if (seq_tick) begin
      if (seq_q == LAST) seq_q <= '0;
      else               seq_q <= seq_q + 1'b1;
    end
  end
endmodule

// File: rtl/cbr_control.sv
module cbr_control
  import cbr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busoff_evt,
  input  logic init_wr_en,
  input  logic init_wr_data,
  input  logic seq_done,
  output logic count_en,
  output logic init_bit,
  output logic bus_en,
  output logic done_pulse
);
  ctl_state_e state_q, state_d;
  logic done_q;

  always_comb begin
    state_d = state_q;
    if (busoff_evt) begin
      state_d = ST_BO_HELD;
    end else begin
      unique case (state_q)
        ST_CONFIG:   if (init_wr_en && !init_wr_data) state_d = ST_ACTIVE;
        ST_ACTIVE:   if (init_wr_en &&  init_wr_data) state_d = ST_CONFIG;
        ST_BO_HELD:  if (init_wr_en && !init_wr_data) state_d = ST_BO_COUNT;
        ST_BO_COUNT: begin
          if (seq_done)
            state_d = (init_wr_en && init_wr_data) ? ST_CONFIG : ST_ACTIVE;
          else if (init_wr_en && init_wr_data)
            state_d = ST_BO_HELD;
        end
        default:     state_d = ST_CONFIG;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_CONFIG;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= seq_done && !busoff_evt && (state_q == ST_BO_COUNT);
    end
  end

  assign count_en   = (state_q == ST_BO_COUNT);
  assign init_bit   = (state_q == ST_CONFIG) || (state_q == ST_BO_HELD);
  assign bus_en     = (state_q == ST_ACTIVE) || done_q;
  assign done_pulse = done_q;
endmodule

// File: rtl/can_busoff_recovery.sv
module can_busoff_recovery #(
  parameter int unsigned RUN_LEN    = 11,
  parameter int unsigned SEQ_NEEDED = 129
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busoff_evt,
  input  logic bit_strobe,
  input  logic rx_bit,
  input  logic init_wr_en,
  input  logic init_wr_data,
  output logic init_bit,
  output logic bus_en,
  output logic recovery_done,
  output logic err_clear
);
  logic count_en;
  logic seq_tick;
  logic seq_done;
  logic done_pulse;

  cbr_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst_n(rst_n), .count_en(count_en),
    .bit_strobe(bit_strobe), .rx_bit(rx_bit), .seq_tick(seq_tick)
  );

  cbr_seq_counter #(.SEQ_NEEDED(SEQ_NEEDED)) u_seq (
    .clk(clk), .rst_n(rst_n), .count_en(count_en),
    .seq_tick(seq_tick), .seq_done(seq_done)
  );

  cbr_control u_ctl (
    .clk(clk), .rst_n(rst_n), .busoff_evt(busoff_evt),
    .init_wr_en(init_wr_en), .init_wr_data(init_wr_data),
    .seq_done(seq_done), .count_en(count_en), .init_bit(init_bit),
    .bus_en(bus_en), .done_pulse(done_pulse)
  );

  assign recovery_done = done_pulse;
  assign err_clear     = done_pulse;
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker (
  input logic clk,
  input logic rst_n,
  input logic busoff_evt,
  input logic bit_strobe,
  input logic rx_bit,
  input logic init_wr_en,
  input logic init_wr_data,
  input logic init_bit,
  input logic bus_en,
  input logic recovery_done,
  input logic err_clear
);
  assert_busoff_forces_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_evt |=> (init_bit && !bus_en && !recovery_done));

  assert_init_blocks_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    init_bit |-> !bus_en);

  assert_done_needs_recessive_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovery_done) |-> $past(bit_strobe && rx_bit && !init_bit));

  assert_done_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_done |=> !recovery_done);

  assert_done_with_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_done |-> (bus_en && err_clear && !init_bit));

  assert_enable_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_en) && !recovery_done) |-> $past(init_wr_en && !init_wr_data));
endmodule

bind can_busoff_recovery cbr_checker u_cbr_checker (
  .clk(clk), .rst_n(rst_n), .busoff_evt(busoff_evt), .bit_strobe(bit_strobe),
  .rx_bit(rx_bit), .init_wr_en(init_wr_en), .init_wr_data(init_wr_data),
  .init_bit(init_bit), .bus_en(bus_en), .recovery_done(recovery_done),
  .err_clear(err_clear)
);

// File: tb/can_busoff_recovery_test.sv
module can_busoff_recovery_test;
  localparam int RUN = 11;
  localparam int SEQ = 129;
  localparam int TOTAL = RUN * SEQ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busoff_evt = 1'b0, bit_strobe = 1'b0, rx_bit = 1'b1;
  logic init_wr_en = 1'b0, init_wr_data = 1'b0;
  logic init_bit, bus_en, recovery_done, err_clear;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  can_busoff_recovery #(.RUN_LEN(RUN), .SEQ_NEEDED(SEQ)) uut (
    .clk(clk), .rst_n(rst_n), .busoff_evt(busoff_evt), .bit_strobe(bit_strobe),
    .rx_bit(rx_bit), .init_wr_en(init_wr_en), .init_wr_data(init_wr_data),
    .init_bit(init_bit), .bus_en(bus_en), .recovery_done(recovery_done),
    .err_clear(err_clear)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    @(negedge clk); bit_strobe = 1'b1; rx_bit = v;
    @(negedge clk); bit_strobe = 1'b0; rx_bit = 1'b1;
  endtask

  task automatic send_recessive(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic write_init(input logic v);
    @(negedge clk); init_wr_en = 1'b1; init_wr_data = v;
    @(negedge clk); init_wr_en = 1'b0;
  endtask

  task automatic pulse_busoff();
    @(negedge clk); busoff_evt = 1'b1;
    @(negedge clk); busoff_evt = 1'b0;
  endtask

  task automatic expect_finish(input string req);
    send_bit(1'b1);
    check({req, " bus_en at completion"}, int'(bus_en), 1);
    check("R8 done pulse", int'(recovery_done), 1);
    check("R8 err_clear pulse", int'(err_clear), 1);
    check("R8 init stays clear", int'(init_bit), 0);
    @(negedge clk);
    check("R8 done one cycle", int'(recovery_done), 0);
    check("R8 bus stays enabled", int'(bus_en), 1);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 init after reset", int'(init_bit), 1);
    check("R1 bus_en after reset", int'(bus_en), 0);
    check("R1 done after reset", int'(recovery_done), 0);
    check("R1 err_clear after reset", int'(err_clear), 0);

    write_init(1'b0);
    check("R2 bus_en after clear", int'(bus_en), 1);
    check("R2 init after clear", int'(init_bit), 0);
    write_init(1'b1);
    check("R2 bus_en after set", int'(bus_en), 0);
    write_init(1'b0);

    @(negedge clk); busoff_evt = 1'b1; init_wr_en = 1'b1; init_wr_data = 1'b0;
    @(negedge clk); busoff_evt = 1'b0; init_wr_en = 1'b0;
    check("R3 init forced", int'(init_bit), 1);
    check("R3 bus disabled", int'(bus_en), 0);

    send_recessive(50);
    write_init(1'b0);
    check("R4 init reads clear", int'(init_bit), 0);
    check("R4 bus still off", int'(bus_en), 0);
    @(negedge clk); rx_bit = 1'b1;
    repeat (2000) @(negedge clk);
    check("R7 no strobe no progress", int'(bus_en), 0);
    send_recessive(TOTAL - 1);
    check("R9 strobes while set not counted", int'(bus_en), 0);
    expect_finish("R5");

    for (int off = 0; off < RUN; off++) begin
      int full;
      full = (off * 13) % SEQ;
      pulse_busoff();
      write_init(1'b0);
      send_recessive(full * RUN + off);
      send_bit(1'b0);
      send_recessive((SEQ - full) * RUN - 1);
      check("R6 partial discarded, full kept", int'(bus_en), 0);
      expect_finish("R6");
    end

    pulse_busoff();
    write_init(1'b0);
    send_recessive(100 * RUN);
    write_init(1'b0);
    write_init(1'b1);
    check("R9 init set again", int'(init_bit), 1);
    check("R9 bus off", int'(bus_en), 0);
    write_init(1'b0);
    send_recessive(TOTAL - 1);
    check("R9 progress discarded", int'(bus_en), 0);
    expect_finish("R9");

    pulse_busoff();
    write_init(1'b0);
    send_recessive(600);
    pulse_busoff();
    check("R10 init set by new busoff", int'(init_bit), 1);
    write_init(1'b0);
    send_recessive(TOTAL - 1);
    check("R10 restarted from zero", int'(bus_en), 0);
    expect_finish("R10");

    write_init(1'b1);
    check("R2 set after recovery", int'(bus_en), 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule